// File: doc/BRIEF.md
# Serial Port Baud Rate Generator

This block turns the system clock into the two timing strobes a serial port needs: a bit-rate tick that marks each bit boundary, and a sample tick for the receiver. An 8-bit divisor value X sets the period of a free-running timer. A prescaler in front of that timer has a fixed ratio that depends on the selected mode. In asynchronous mode with the high-speed select low, the full divide ratio is 64·(X+1). With high-speed select high it is 16·(X+1). In synchronous master mode it is 4·(X+1), and the high-speed select has no effect.

In asynchronous mode the sample tick runs sixteen times faster than the bit tick, to serve a receiver that oversamples each bit. In synchronous mode the sample tick is the bit tick. Any of the following clears the whole divider chain: writing the divisor, changing the mode or high-speed select, or holding the port disabled. A new rate therefore starts from a clean period, and no period ever mixes two ratios. As an example, a 16 MHz system clock with asynchronous low-speed mode and X = 25 gives one bit tick every 1664 clocks, which is about 9615 baud.

Top module: `baud_tick_gen`

## Requirements
- R1: In asynchronous mode (`sync_mode`=0) with `hi_speed`=0, `bit_tick` repeats every 64·(X+1) clocks and `sample_tick` every 4·(X+1) clocks.
- R2: In asynchronous mode with `hi_speed`=1, `bit_tick` repeats every 16·(X+1) clocks and `sample_tick` every (X+1) clocks.
- R3: In synchronous mode (`sync_mode`=1), `bit_tick` repeats every 4·(X+1) clocks whatever the value of `hi_speed`, and `sample_tick` equals `bit_tick` in every cycle.
- R4: The divisor is an 8-bit value X from 0 to 255. It changes only in a cycle with `div_we`=1, and reset sets it to 0.
- R5: A divisor write clears the prescaler, timer and oversample counter. If `div_we` is high in the cycle before clock edge k, no tick appears before edge k+N, and the first `bit_tick` is high just after edge k+N, where N is the full period for the new X.
- R6: A change of `sync_mode` or `hi_speed` clears the divider chain in the same way. The first `bit_tick` after the change comes 1+N edges after the cycle in which the new value is first presented.
- R7: While `port_en`=0, no ticks are produced and the counters are held at zero. After `port_en` is raised, the first `bit_tick` is high just after the N-th rising edge.
- R8: `bit_tick` is never high in two consecutive cycles, and it keeps a fixed period while the divisor, mode and enable are stable.
- R9: With asynchronous low-speed mode and X = 25, the bit period is exactly 1664 clocks.
- R10: In asynchronous mode, exactly 16 `sample_tick` pulses fall in each bit period, and every `bit_tick` coincides with a `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_en | input | 1 | Serial port enable; low holds the divider chain cleared |
| div_wdata | input | 8 | New divisor value X |
| div_we | input | 1 | Divisor write strobe; also restarts the chain |
| sync_mode | input | 1 | 0 = asynchronous, 1 = synchronous master |
| hi_speed | input | 1 | Asynchronous high-speed select (ignored when synchronous) |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| sample_tick | output | 1 | Receiver sample pulse (16 per bit asynchronous, same as bit_tick synchronous) |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, sixteen-fold oversampling, and full ratios of 64, 16 and 4. These defaults put the whole divisor range within a short run. The vectors cover the minimum X = 0 and the maximum X = 255, so the longest period of 16384 clocks is measured edge by edge in each mode. The short periods, down to 16 clocks, make it practical to restart the chain in the middle of a period by a divisor write, a mode change, a high-speed change or an enable drop, and to check that no early tick escapes.

// File: rtl/baud_pkg.sv
// Package: shared configuration type for the baud tick generator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package baud_pkg;

    // Mode configuration as latched by the generator
    typedef struct packed {
        logic sync;   // 1 = synchronous master mode
        logic fast;   // asynchronous high-speed select
    } baud_cfg_t;

endpackage

// File: rtl/baud_div_reg.sv
// Module: divisor holding register.
// Stores the period value X written through the strobe. Assumes the strobe
// is a single-cycle synchronous pulse; resets to zero.
module baud_div_reg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div_q
);

    // Load the divisor on a write, clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (we) begin
            div_q <= wdata;
        end
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(div_q)); // R4

endmodule

// File: rtl/baud_prescaler.sv
// Module: mode-selected fixed prescaler.
// Emits one pulse every RATIO clocks, where RATIO is picked by the latched
// configuration. Assumes run drops for at least one cycle whenever the
// configuration changes, so the count never exceeds the new limit.
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int SLOW_RATIO = 4,
    parameter int FAST_RATIO = 1,
    parameter int SYNC_RATIO = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  baud_cfg_t cfg,
    output logic      pre_tick
);

    localparam int MAX_RATIO = (SLOW_RATIO > FAST_RATIO)
                             ? ((SLOW_RATIO > SYNC_RATIO) ? SLOW_RATIO : SYNC_RATIO)
                             : ((FAST_RATIO > SYNC_RATIO) ? FAST_RATIO : SYNC_RATIO);
    localparam int CNT_W = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(SLOW_RATIO - 1);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(FAST_RATIO - 1);
    localparam logic [CNT_W-1:0] LIM_SYNC = CNT_W'(SYNC_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Pick the terminal count for the current mode
    always_comb begin
        if (cfg.sync) begin
            limit = LIM_SYNC;
        end else if (cfg.fast) begin
            limit = LIM_FAST;
        end else begin
            limit = LIM_SLOW;
        end
    end

    assign pre_tick = run && (cnt_q == limit);

    // Count prescaler clocks, wrapping at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit); // R6

endmodule

// File: rtl/baud_period_timer.sv
// Module: programmable period timer.
// Counts X+1 prescaler pulses per period and flags the last one. Assumes
// run is dropped for a cycle whenever the divisor is rewritten.
module baud_period_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] div_q,
    output logic             tmr_tick
);

    logic [DIV_W-1:0] tcnt_q;

    assign tmr_tick = pre_tick && (tcnt_q == div_q);

    // Advance once per prescaler pulse, wrap after X+1 pulses
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tcnt_q <= '0;
        end else if (pre_tick) begin
            tcnt_q <= (tcnt_q == div_q) ? '0 : tcnt_q + 1'b1;
        end
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt_q <= div_q); // R5

endmodule

// File: rtl/baud_ovs_div.sv
// Module: oversample divider.
// In asynchronous mode turns every OVS-th timer pulse into a bit pulse; in
// synchronous mode passes the timer pulse straight through. The timer pulse
// itself is the sample pulse. Assumes OVS is a power of two.
module baud_ovs_div #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sync,
    input  logic tmr_tick,
    output logic bit_raw,
    output logic sample_raw
);

    localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

    logic [OVS_W-1:0] ocnt_q;

    assign sample_raw = tmr_tick;
    assign bit_raw    = sync ? tmr_tick : (tmr_tick && (ocnt_q == OVS_LAST));

    // Count sample pulses within a bit, asynchronous mode only
    always_ff @(posedge clk) begin
        if (!rst_n || !run || sync) begin
            ocnt_q <= '0;
        end else if (tmr_tick) begin
            ocnt_q <= ocnt_q + 1'b1;
        end
    end

    AST_OVS_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync && $past(run) && $past(sync)) |-> (ocnt_q == '0)); // R3

endmodule

// File: rtl/baud_tick_gen.sv
// Module: serial port baud tick generator (top).
// Chains a mode-selected prescaler, an X+1 period timer and an oversample
// divider, then registers the bit and sample pulses. A divisor write, a mode
// or speed change, or a low enable clears the chain. Assumes all inputs are
// synchronous to clk.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int OVS         = 16,
    parameter int ASYNC_SLOW  = 64,
    parameter int ASYNC_FAST  = 16,
    parameter int SYNC_RATIO  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             div_we,
    input  logic             sync_mode,
    input  logic             hi_speed,
    output logic             bit_tick,
    output logic             sample_tick
);

    localparam int PRE_SLOW = ASYNC_SLOW / OVS;
    localparam int PRE_FAST = ASYNC_FAST / OVS;

    baud_cfg_t        cfg_in;
    baud_cfg_t        cfg_q;
    logic             cfg_chg;
    logic             run;
    logic [DIV_W-1:0] div_q;
    logic             pre_tick;
    logic             tmr_tick;
    logic             bit_raw;
    logic             sample_raw;

    assign cfg_in  = '{sync: sync_mode, fast: hi_speed};
    assign cfg_chg = (cfg_in != cfg_q);
    assign run     = port_en && !div_we && !cfg_chg;

    // Latch the mode so a change is seen as a one-cycle restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_in;
        end
    end

    baud_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (div_we),
        .wdata (div_wdata),
        .div_q (div_q)
    );

    baud_prescaler #(
        .SLOW_RATIO (PRE_SLOW),
        .FAST_RATIO (PRE_FAST),
        .SYNC_RATIO (SYNC_RATIO)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cfg      (cfg_q),
        .pre_tick (pre_tick)
    );

    baud_period_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pre_tick (pre_tick),
        .div_q    (div_q),
        .tmr_tick (tmr_tick)
    );

    baud_ovs_div #(.OVS(OVS)) u_ovs (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sync       (cfg_q.sync),
        .tmr_tick   (tmr_tick),
        .bit_raw    (bit_raw),
        .sample_raw (sample_raw)
    );

    // Register the pulses so the outputs are glitch-free flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_tick    <= 1'b0;
            sample_tick <= 1'b0;
        end else begin
            bit_tick    <= bit_raw;
            sample_tick <= sample_raw;
        end
    end

    AST_BIT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!bit_tick && !sample_tick)); // R7
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> (!bit_tick && !sample_tick)); // R5
    AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!bit_tick && !sample_tick)); // R6
    AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick); // R10
    AST_SYNC_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.sync |-> (bit_tick == sample_tick)); // R3

endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       div_we = 1'b0;
    logic       sync_mode = 1'b0;
    logic       hi_speed = 1'b0;
    logic       bit_tick;
    logic       sample_tick;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    baud_tick_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en     (port_en),
        .div_wdata   (div_wdata),
        .div_we      (div_we),
        .sync_mode   (sync_mode),
        .hi_speed    (hi_speed),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick)
    );

    typedef struct packed {
        logic       sync;
        logic       fast;
        logic [7:0] x;
        int         bitp;
        int         sampp;
    } vec_t;

    // Expected periods from the ratio formulas of R1..R3
    localparam vec_t VECS [0:8] = '{
        '{1'b0, 1'b0, 8'd25,  1664,  104},   // R9 case
        '{1'b0, 1'b1, 8'd25,  416,   26},
        '{1'b1, 1'b0, 8'd25,  104,   104},
        '{1'b1, 1'b1, 8'd25,  104,   104},   // speed bit ignored
        '{1'b0, 1'b0, 8'd0,   64,    4},
        '{1'b0, 1'b1, 8'd3,   64,    4},
        '{1'b1, 1'b0, 8'd255, 1024,  1024},
        '{1'b0, 1'b1, 8'd255, 4096,  256},
        '{1'b0, 1'b0, 8'd255, 16384, 1024}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Disable, set mode, write divisor, settle; ends just after a negedge
    task automatic setup(input logic s, input logic f, input logic [7:0] x);
        @(negedge clk);
        port_en = 1'b0;
        sync_mode = s;
        hi_speed = f;
        @(negedge clk);
        div_wdata = x;
        div_we = 1'b1;
        @(negedge clk);
        div_we = 1'b0;
        @(negedge clk);
    endtask

    // Count edges until the first bit tick, up to a limit
    task automatic first_bit(input int lim, output int at);
        at = 0;
        for (int e = 1; e <= lim; e++) begin
            @(negedge clk);
            if (bit_tick && at == 0) at = e;
        end
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        int fb;
        int sb;
        int fs;
        int nsamp;
        int wide;
        int mism;
        int quiet;
        logic prev;
        string tag;

        repeat (3) @(negedge clk);
        check(bit_tick == 1'b0 && sample_tick == 1'b0, "R7 reset outputs", int'(bit_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: divisor resets to 0 -> asynchronous fast period 16 with no write
        hi_speed = 1'b1;
        @(negedge clk);
        port_en = 1'b1;
        first_bit(40, fb);
        check(fb == 16, "R4 reset divisor zero", fb, 16);

        // Vector table walk
        for (int i = 0; i <= 8; i++) begin
            setup(VECS[i].sync, VECS[i].fast, VECS[i].x);
            tag = VECS[i].sync ? "R3" : (VECS[i].fast ? "R2" : "R1");
            port_en = 1'b1;
            fb = 0; sb = 0; fs = 0; nsamp = 0; wide = 0; mism = 0; prev = 1'b0;
            for (int e = 1; e <= 2 * VECS[i].bitp + 4; e++) begin
                @(negedge clk);
                if (sample_tick && fs == 0) fs = e;
                if (bit_tick) begin
                    if (fb == 0) fb = e;
                    else if (sb == 0) sb = e;
                end
                if (fb != 0 && e > fb && (sb == 0 || e == sb) && sample_tick) nsamp++;
                if (bit_tick && prev) wide++;
                prev = bit_tick;
                if (VECS[i].sync && (bit_tick != sample_tick)) mism++;
            end
            check(fb == VECS[i].bitp, {tag, " R7 first bit after enable"}, fb, VECS[i].bitp);
            check(sb - fb == VECS[i].bitp, {tag, " R8 bit period"}, sb - fb, VECS[i].bitp);
            check(fs == VECS[i].sampp, {tag, " first sample"}, fs, VECS[i].sampp);
            check(wide == 0, "R8 single-cycle bit tick", wide, 0);
            if (VECS[i].sync) begin
                check(mism == 0, "R3 sample equals bit", mism, 0);
            end else begin
                check(nsamp == 16, "R10 samples per bit", nsamp, 16);
            end
            if (i == 0) check(sb - fb == 1664, "R9 16MHz 9615 baud example", sb - fb, 1664);
        end

        // R7: disabled port stays quiet
        setup(1'b0, 1'b1, 8'd0);
        quiet = 0;
        for (int e = 0; e < 200; e++) begin
            @(negedge clk);
            if (bit_tick || sample_tick) quiet++;
        end
        check(quiet == 0, "R7 no ticks while disabled", quiet, 0);

        // R7: enable drop mid-run, then restart
        setup(1'b0, 1'b1, 8'd3);
        port_en = 1'b1;
        repeat (40) @(negedge clk);
        port_en = 1'b0;
        quiet = 0;
        for (int e = 0; e < 100; e++) begin
            @(negedge clk);
            if (bit_tick || sample_tick) quiet++;
        end
        check(quiet == 0, "R7 quiet after enable drop", quiet, 0);
        port_en = 1'b1;
        first_bit(100, fb);
        check(fb == 64, "R7 restart full period", fb, 64);

        // R5: divisor write mid-period restarts at the new rate
        setup(1'b0, 1'b0, 8'd25);
        port_en = 1'b1;
        repeat (1000) @(negedge clk);
        div_wdata = 8'd9;
        div_we = 1'b1;
        fb = 0;
        for (int e = 1; e <= 800; e++) begin
            @(negedge clk);
            if (e == 1) div_we = 1'b0;
            if (bit_tick && fb == 0) fb = e;
        end
        check(fb == 641, "R5 write clears timer", fb, 641);

        // R6: speed change in asynchronous mode
        setup(1'b0, 1'b1, 8'd3);
        port_en = 1'b1;
        repeat (30) @(negedge clk);
        hi_speed = 1'b0;
        first_bit(400, fb);
        check(fb == 257, "R6 speed change restarts", fb, 257);

        // R6: speed toggle in synchronous mode still restarts
        setup(1'b1, 1'b0, 8'd3);
        port_en = 1'b1;
        repeat (20) @(negedge clk);
        hi_speed = 1'b1;
        first_bit(40, fb);
        check(fb == 17, "R6 sync speed toggle restarts", fb, 17);

        // R6: mode switch from synchronous to asynchronous
        @(negedge clk);
        sync_mode = 1'b0;
        first_bit(100, fb);
        check(fb == 65, "R6 mode change restarts", fb, 65);

        report();
    end

endmodule